// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog down-counter that asserts a reset request when software stops servicing it. Each service write reloads the counter from a programmed load value. In the optional secure mode a service write counts only if its data equals the current value of a hidden 8-bit key sequence. Each accepted write then moves the sequence on by one step. A write with the wrong data asks for reset at once, before the counter has expired.

Software programs the seed through the same write channel while the watchdog is stopped. It then raises the enable with the secure bit set or cleared. From then on it must present the key values in order. The key register has no read path, so software computes the sequence itself. The step is a left shift of the 8-bit key. When the bit shifted out is 1, the shifted value is XORed with 0x63. This is the feedback polynomial x^8 + x^6 + x^5 + x + 1.

Service and seed writes arrive on a valid/ready channel. `wr_ready` is high in every state except the halted state that follows a reset request. No back-pressure is applied while the watchdog is stopped or running. A write is taken on a rising edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, offered data is dropped and has no effect. The configuration pins are plain levels.

Top module: `wdt_lfsr_guard`

## Requirements
- R1: The key advances as follows: shift left by one, then XOR with 0x63 if the bit shifted out was 1. Starting from seed 0xAA, the accepted service values are 0xAA, 0x37, 0x6E and 0xDC, in that order.
- R2: A write taken while `cfg_enable` is low stores `wr_data` as the seed. The first value expected after start equals that seed.
- R3: In secure mode, a service write whose data equals the expected key reloads the counter, advances the key and raises no reset request.
- R4: In secure mode, a service write whose data differs from the expected key raises `reset_req` in the cycle after the write edge, even if the counter is far from zero.
- R5: If secure mode is selected and the stored seed is 0x00, `reset_req` is high in the cycle after the edge where `cfg_enable` is first sampled high.
- R6: With secure mode off, any service write reloads the counter, whatever its data.
- R7: Let the start edge be E0, the first edge where `cfg_enable` is sampled high, with load value L. If no service write follows, `reset_req` stays low through edge E(L) and is high after edge E(L+1).
- R8: `reset_req` is a one-cycle pulse. After it the block halts with `wr_ready` low until `cfg_enable` is sampled low. It then returns to the stopped state with `wr_ready` high.
- R9: After `rst_n` is released, `reset_req` is low and `wr_ready` is high.
- R10: `cfg_secure` is sampled only at the start edge. Changing it while the watchdog runs has no effect on how service writes are judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | High runs the watchdog; low stops it |
| cfg_secure | input | 1 | Selects keyed service; sampled at start |
| cfg_load_val | input | CNT_W | Counter value loaded at start and at each reload |
| wr_valid | input | 1 | Write channel valid |
| wr_ready | output | 1 | Write channel ready; low while halted |
| wr_data | input | KEY_W | Seed (while stopped) or service value (while running) |
| reset_req | output | 1 | One-cycle reset request pulse |

## Verification
Every result is registered, so each one shows one edge after the edge that caused it. A service write decides `reset_req` on the next edge. A zero seed raises it one edge after the start edge. A timeout raises it L+1 edges after the start edge, or after the last accepted write. The bench changes inputs one nanosecond after a rising edge and reads outputs at the same offset after the following edge. Each check therefore sees the state that exactly one edge produced. The timeout check looks at `reset_req` after every edge from E1 to E(L+1). The reload checks wait 15 cycles with a load value of 20, so a missed reload would show up as a reset.

// File: rtl/wdt_lfsr_pkg.sv
package wdt_lfsr_pkg;

  // Controller states
  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,  // stopped, seed writes accepted
    WD_RUN  = 2'd1,  // counting, service writes judged
    WD_HALT = 2'd2   // after a reset request, waits for enable low
  } wd_state_e;

endpackage

// File: rtl/wdt_keygen.sv
module wdt_keygen #(
  parameter int unsigned           KEY_W    = 8,
  parameter logic [KEY_W-1:0]      KEY_TAPS = 8'h63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_we,
  input  logic [KEY_W-1:0] seed_in,
  input  logic             arm,
  input  logic             adv,
  output logic [KEY_W-1:0] key_o,
  output logic             seed_zero_o
);

  logic [KEY_W-1:0] seed_q;
  logic [KEY_W-1:0] key_q;
  logic [KEY_W-1:0] key_shift;
  logic [KEY_W-1:0] key_next;

  // Galois-style step: shift left, fold taps when the MSB leaves
  assign key_shift = {key_q[KEY_W-2:0], 1'b0};
  assign key_next  = key_q[KEY_W-1] ? (key_shift ^ KEY_TAPS) : key_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q <= '0;
    end else if (seed_we) begin
      seed_q <= seed_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
    end else if (arm) begin
      key_q <= seed_q;
    end else if (adv) begin
      key_q <= key_next;
    end
  end

  assign key_o       = key_q;
  assign seed_zero_o = (seed_q == '0);

  // R1: a nonzero key never steps into the all-zero lock state
  a_r1_key_nonzero : assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !arm && key_q != '0) |=> (key_q != '0));

  // R3: key holds unless armed or advanced by an accepted service write
  a_r3_key_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !arm) |=> $stable(key_q));

  // R2: arming copies the stored seed
  a_r2_arm_seed : assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !seed_we) |=> (key_q == seed_q));

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R6: a reload takes the programmed value
  a_r6_reload : assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R7: a decrement removes exactly one
  a_r7_dec_one : assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

  // R7: the count never wraps past zero
  a_r7_no_wrap : assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_lfsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic secure,
  input  logic wr_fire,
  input  logic data_match,
  input  logic seed_zero,
  input  logic cnt_zero,
  output logic seed_we,
  output logic arm,
  output logic adv,
  output logic reload,
  output logic dec,
  output logic wr_ready,
  output logic reset_req
);

  wd_state_e state_q, state_d;
  logic      secure_q, secure_d;
  logic      fire;
  logic      req_q;

  always_comb begin
    state_d  = state_q;
    secure_d = secure_q;
    seed_we  = 1'b0;
    arm      = 1'b0;
    adv      = 1'b0;
    reload   = 1'b0;
    dec      = 1'b0;
    fire     = 1'b0;
    unique case (state_q)
      WD_IDLE: begin
        seed_we = wr_fire;
        if (enable) begin
          arm      = 1'b1;
          reload   = 1'b1;
          secure_d = secure;
          if (secure && seed_zero) begin
            fire    = 1'b1;
            state_d = WD_HALT;
          end else begin
            state_d = WD_RUN;
          end
        end
      end
      WD_RUN: begin
        if (!enable) begin
          state_d = WD_IDLE;
        end else if (wr_fire) begin
          if (!secure_q || data_match) begin
            reload = 1'b1;
            adv    = secure_q;
          end else begin
            fire    = 1'b1;
            state_d = WD_HALT;
          end
        end else if (cnt_zero) begin
          fire    = 1'b1;
          state_d = WD_HALT;
        end else begin
          dec = 1'b1;
        end
      end
      WD_HALT: begin
        if (!enable) begin
          state_d = WD_IDLE;
        end
      end
      default: state_d = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WD_IDLE;
      secure_q <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      secure_q <= secure_d;
      req_q    <= fire;
    end
  end

  assign wr_ready  = (state_q != WD_HALT);
  assign reset_req = req_q;

  // R8: the request lasts one cycle
  a_r8_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R8: no writes are taken while the request is showing
  a_r8_halt_ready : assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> !wr_ready);

  // R4: wrong key in secure mode requests reset next cycle
  a_r4_mismatch : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_RUN && enable && wr_fire && secure_q && !data_match) |=> reset_req);

  // R3: correct key gives no request
  a_r3_match : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_RUN && enable && wr_fire && secure_q && data_match) |=> !reset_req);

  // R6: plain mode never judges the data
  a_r6_plain : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_RUN && enable && wr_fire && !secure_q) |=> !reset_req);

  // R7: expiry without service requests reset
  a_r7_timeout : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_RUN && enable && !wr_fire && cnt_zero) |=> reset_req);

  // R5: zero seed in secure mode fails at start
  a_r5_zero_seed : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_IDLE && enable && secure && seed_zero) |=> reset_req);

  // R10: latched mode holds while running
  a_r10_mode_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_RUN) |=> $stable(secure_q));

endmodule

// File: rtl/wdt_lfsr_guard.sv
module wdt_lfsr_guard #(
  parameter int unsigned      CNT_W    = 16,
  parameter int unsigned      KEY_W    = 8,
  parameter logic [KEY_W-1:0] KEY_TAPS = 8'h63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_secure,
  input  logic [CNT_W-1:0] cfg_load_val,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [KEY_W-1:0] wr_data,
  output logic             reset_req
);

  logic             wr_fire;
  logic             data_match;
  logic [KEY_W-1:0] key;
  logic             seed_zero;
  logic             cnt_zero;
  logic             seed_we;
  logic             arm;
  logic             adv;
  logic             reload;
  logic             dec;

  assign wr_fire    = wr_valid & wr_ready;
  assign data_match = (wr_data == key);

  wdt_keygen #(
    .KEY_W    (KEY_W),
    .KEY_TAPS (KEY_TAPS)
  ) u_keygen (
    .clk         (clk),
    .rst_n       (rst_n),
    .seed_we     (seed_we),
    .seed_in     (wr_data),
    .arm         (arm),
    .adv         (adv),
    .key_o       (key),
    .seed_zero_o (seed_zero)
  );

  wdt_countdown #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reload),
    .load_val (cfg_load_val),
    .dec      (dec),
    .zero_o   (cnt_zero)
  );

  wdt_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cfg_enable),
    .secure     (cfg_secure),
    .wr_fire    (wr_fire),
    .data_match (data_match),
    .seed_zero  (seed_zero),
    .cnt_zero   (cnt_zero),
    .seed_we    (seed_we),
    .arm        (arm),
    .adv        (adv),
    .reload     (reload),
    .dec        (dec),
    .wr_ready   (wr_ready),
    .reset_req  (reset_req)
  );

endmodule

// File: tb/wdt_lfsr_guard_tb.sv
module wdt_lfsr_guard_tb_top;

  localparam int CNT_W = 16;
  localparam int KEY_W = 8;
  localparam int LOADV = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_enable = 1'b0;
  logic             cfg_secure = 1'b0;
  logic [CNT_W-1:0] cfg_load_val = CNT_W'(LOADV);
  logic             wr_valid = 1'b0;
  logic             wr_ready;
  logic [KEY_W-1:0] wr_data = '0;
  logic             reset_req;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  wdt_lfsr_guard #(.CNT_W(CNT_W), .KEY_W(KEY_W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .cfg_secure   (cfg_secure),
    .cfg_load_val (cfg_load_val),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_data      (wr_data),
    .reset_req    (reset_req)
  );

  function automatic logic [7:0] key_step(input logic [7:0] k);
    logic [7:0] s;
    s = {k[6:0], 1'b0};
    return k[7] ? (s ^ 8'h63) : s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic stop_wd();
    cfg_enable = 1'b0;
    tick();
    tick();
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      tick();
      chk(reset_req == 1'b0, req, "no request while serviced", int'(reset_req), 0);
    end
  endtask

  task automatic t_reset_state();
    chk(reset_req == 1'b0, "R9", "reset_req after reset", int'(reset_req), 0);
    chk(wr_ready == 1'b1, "R9", "wr_ready after reset", int'(wr_ready), 1);
  endtask

  task automatic t_example_seq();
    logic [7:0] exp_seq [4];
    exp_seq[0] = 8'hAA; exp_seq[1] = 8'h37; exp_seq[2] = 8'h6E; exp_seq[3] = 8'hDC;
    for (int i = 0; i < 3; i++)
      chk(key_step(exp_seq[i]) == exp_seq[i+1], "R1", "model step", key_step(exp_seq[i]), exp_seq[i+1]);
    wr(8'hAA);                     // R2: seed stored while stopped
    cfg_secure = 1'b1;
    cfg_enable = 1'b1;
    tick();
    chk(reset_req == 1'b0, "R2", "start with seed 0xAA", int'(reset_req), 0);
    for (int i = 0; i < 3; i++) begin
      wr(exp_seq[i]);
      chk(reset_req == 1'b0, "R3", "matching key accepted", int'(reset_req), 0);
      quiet(15, "R3");
    end
    wr(8'h66);                     // 0xDC expected
    chk(reset_req == 1'b1, "R4", "wrong key 0x66 requests reset", int'(reset_req), 1);
    tick();
    chk(reset_req == 1'b0, "R8", "request is one cycle", int'(reset_req), 0);
    chk(wr_ready == 1'b0, "R8", "halted after request", int'(wr_ready), 0);
    stop_wd();
    chk(wr_ready == 1'b1, "R8", "ready after enable low", int'(wr_ready), 1);
  endtask

  task automatic t_long_seq();
    logic [7:0] k;
    k = 8'h01;
    wr(k);
    cfg_secure = 1'b1;
    cfg_enable = 1'b1;
    tick();
    for (int i = 0; i < 12; i++) begin
      wr(k);
      chk(reset_req == 1'b0, "R1", "modelled key accepted", int'(reset_req), 0);
      k = key_step(k);
      tick(); tick();
    end
    wr(k ^ 8'h01);
    chk(reset_req == 1'b1, "R4", "off-by-one-bit key", int'(reset_req), 1);
    stop_wd();
  endtask

  task automatic t_zero_seed();
    wr(8'h00);
    cfg_secure = 1'b1;
    cfg_enable = 1'b1;
    tick();
    chk(reset_req == 1'b1, "R5", "zero seed at start", int'(reset_req), 1);
    stop_wd();
  endtask

  task automatic t_timeout();
    cfg_secure = 1'b0;
    cfg_enable = 1'b1;
    tick();                        // E0
    for (int i = 1; i <= LOADV; i++) begin
      tick();
      chk(reset_req == 1'b0, "R7", "before expiry", int'(reset_req), 0);
    end
    tick();                        // E(L+1)
    chk(reset_req == 1'b1, "R7", "expiry request", int'(reset_req), 1);
    tick();
    chk(reset_req == 1'b0, "R8", "timeout pulse ends", int'(reset_req), 0);
    wr_valid = 1'b1; wr_data = 8'h5A;
    tick();
    wr_valid = 1'b0;
    chk(wr_ready == 1'b0, "R8", "write dropped while halted", int'(wr_ready), 0);
    stop_wd();
  endtask

  task automatic t_plain_and_mode_hold();
    cfg_secure = 1'b0;
    cfg_enable = 1'b1;
    tick();
    for (int i = 0; i < 3; i++) begin
      wr(8'h11 * (i + 1));
      chk(reset_req == 1'b0, "R6", "plain write reloads", int'(reset_req), 0);
      quiet(15, "R6");
    end
    cfg_secure = 1'b1;             // ignored while running
    wr(8'h3C);
    chk(reset_req == 1'b0, "R10", "secure bit change ignored", int'(reset_req), 0);
    quiet(15, "R10");
    stop_wd();
    cfg_secure = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset_state();
    t_example_seq();
    t_long_seq();
    t_zero_seed();
    t_timeout();
    t_plain_and_mode_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule